// File: doc/BRIEF.md
# Firmware-Space Address Remap Window

This block sits between a host-side bus front end and the local interconnect. The host issues firmware-space reads and writes through the front end. For each request the block decides whether the address falls inside one programmable window. If it does, the block produces the local-bus address the access should go to. The window is built from 64 KiB pages: only address bits [31:16] take part in matching and translation, and bits [15:0] always pass through unchanged.

Local firmware programs the window through a plain register port. The port holds three 32-bit registers:

- a control register, whose two enable bits gate the whole window;
- a base register that packs the local base page and the host base page;
- a mask register whose upper half picks the page bits taken from the local base and whose lower half picks the page bits kept from the host address.

For a window of power-of-two size S, the upper half of the mask is the top 16 bits of ~(S-1) and the lower half is (S>>16)-1.

Requests arrive as a one-cycle valid strobe with an address and a firmware-cycle flag. Each request is accepted in the cycle it is strobed, and a request may be strobed every cycle. Exactly one clock later the block raises `res_valid` together with the hit flag and the translated address. There is no ready signal: the block cannot stall, so the consumer must take each result in the cycle `res_valid` is high.

Top module: `fwh_remap_window`

## Requirements
- R1: After reset, all three registers read zero, `res_valid` and `res_hit` are low, `res_addr` is zero, and every request misses.
- R2: Register offsets are: control at 0x0, base at 0x8, mask at 0xC. A read returns the last value written there in full. A write to any other offset is ignored and a read of any other offset returns zero.
- R3: A request can hit only while both control bit 10 (firmware-cycle enable) and control bit 8 (host-to-local forwarding enable) are 1. With either bit at 0, every request misses.
- R4: A request whose firmware-cycle flag `req_fw` is 0 always misses.
- R5: An enabled firmware request hits when every bit of `req_addr[31:16]` whose mask-lower-half bit is 0 equals the matching bit of base[15:0] (the host base page).
- R6: On a hit, `res_addr[31:16]` = (base[31:16] AND mask[31:16]) OR (`req_addr[31:16]` AND mask[15:0]).
- R7: On a hit, `res_addr[15:0]` equals `req_addr[15:0]`.
- R8: On a miss, `res_hit` is 0 and `res_addr` is zero.
- R9: `res_valid` is high in exactly the cycle after each cycle in which `req_valid` is high, and low otherwise.
- R10: A register write in the same cycle as a request does not affect that request. The new value applies from the next request onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| req_valid | input | 1 | Host request strobe |
| req_fw | input | 1 | Request is a firmware-hub cycle |
| req_addr | input | 32 | Host firmware-space address |
| res_valid | output | 1 | Result strobe, one cycle after `req_valid` |
| res_hit | output | 1 | Request fell inside the window |
| res_addr | output | 32 | Translated local address, zero on miss |

## Verification
The assertions assume that `req_valid`, `req_fw`, `req_addr` and the register inputs are stable around each rising edge and are driven low while reset is applied. They also assume the result consumer never needs to stall. The stimulus changes every input only on falling edges, holds everything idle during reset, and samples results on falling edges, so no back-pressure is ever needed. Window programming covers both well-formed power-of-two windows and deliberately irregular mask halves, because the translation rule must hold for any mask contents and not only for legal ones.

// File: rtl/fwh_remap_pkg.sv
package fwh_remap_pkg;
  localparam int ADDR_W  = 32;
  localparam int PAGE_W  = ADDR_W / 2;
  localparam int REG_AW  = 4;

  localparam logic [REG_AW-1:0] OFF_CTRL = 4'h0;
  localparam logic [REG_AW-1:0] OFF_BASE = 4'h8;
  localparam logic [REG_AW-1:0] OFF_MASK = 4'hC;

  localparam int EN_FWCYC_BIT = 10;
  localparam int EN_FWD_BIT   = 8;

  typedef struct packed {
    logic              enabled;
    logic [PAGE_W-1:0] local_page;
    logic [PAGE_W-1:0] host_page;
    logic [PAGE_W-1:0] take_local;
    logic [PAGE_W-1:0] keep_host;
  } win_cfg_t;
endpackage

// File: rtl/fwh_remap_regs.sv
module fwh_remap_regs
  import fwh_remap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output win_cfg_t          cfg
);
  logic [ADDR_W-1:0] ctrl_q, base_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      base_q <= '0;
      mask_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFF_CTRL: ctrl_q <= reg_wdata;
        OFF_BASE: base_q <= reg_wdata;
        OFF_MASK: mask_q <= reg_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      OFF_CTRL: reg_rdata = ctrl_q;
      OFF_BASE: reg_rdata = base_q;
      OFF_MASK: reg_rdata = mask_q;
      default:  reg_rdata = '0;
    endcase
  end

  always_comb begin
    cfg.enabled    = ctrl_q[EN_FWCYC_BIT] & ctrl_q[EN_FWD_BIT];
    cfg.local_page = base_q[ADDR_W-1:PAGE_W];
    cfg.host_page  = base_q[PAGE_W-1:0];
    cfg.take_local = mask_q[ADDR_W-1:PAGE_W];
    cfg.keep_host  = mask_q[PAGE_W-1:0];
  end

  // R2: a write to the base offset is held in the register
  a_r2_base_store: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_BASE) |=> base_q == $past(reg_wdata));
  // R2: a write to the mask offset is held in the register
  a_r2_mask_store: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_MASK) |=> mask_q == $past(reg_wdata));
endmodule

// File: rtl/fwh_remap_xlate.sv
module fwh_remap_xlate
  import fwh_remap_pkg::*;
(
  input  win_cfg_t          cfg,
  input  logic              req_fw,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              hit,
  output logic [ADDR_W-1:0] xl_addr
);
  logic [PAGE_W-1:0] page_in;
  logic [PAGE_W-1:0] page_diff;
  logic [PAGE_W-1:0] page_out;

  assign page_in = req_addr[ADDR_W-1:PAGE_W];

  for (genvar i = 0; i < PAGE_W; i++) begin : g_page_bit
    assign page_diff[i] = ~cfg.keep_host[i] & (page_in[i] ^ cfg.host_page[i]);
    assign page_out[i]  = (cfg.local_page[i] & cfg.take_local[i]) |
                          (page_in[i] & cfg.keep_host[i]);
  end

  assign hit     = cfg.enabled & req_fw & ~(|page_diff);
  assign xl_addr = {page_out, req_addr[PAGE_W-1:0]};
endmodule

// File: rtl/fwh_remap_stage.sv
module fwh_remap_stage
  import fwh_remap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_hit,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  output logic              out_hit,
  output logic [ADDR_W-1:0] out_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      out_hit   <= in_valid & in_hit;
      out_addr  <= (in_valid && in_hit) ? in_addr : '0;
    end
  end
endmodule

// File: rtl/fwh_remap_window.sv
module fwh_remap_window
  import fwh_remap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              req_valid,
  input  logic              req_fw,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic [ADDR_W-1:0] res_addr
);
  win_cfg_t          cfg;
  logic              xl_hit;
  logic [ADDR_W-1:0] xl_addr;

  fwh_remap_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg(cfg)
  );

  fwh_remap_xlate u_xlate (
    .cfg(cfg), .req_fw(req_fw), .req_addr(req_addr),
    .hit(xl_hit), .xl_addr(xl_addr)
  );

  fwh_remap_stage u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_hit(xl_hit),
    .in_addr(xl_addr), .out_valid(res_valid), .out_hit(res_hit),
    .out_addr(res_addr)
  );

  // R9: every request strobe yields a result one cycle later
  a_r9_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  // R9: no result without a request
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);
  // R3: a disabled window never hits
  a_r3_disabled_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cfg.enabled) |=> !res_hit);
  // R4: non-firmware cycles never hit
  a_r4_non_fw_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_fw) |=> !res_hit);
  // R7: page offset passes through on a hit
  a_r7_low_pass: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_addr[PAGE_W-1:0] == $past(req_addr[PAGE_W-1:0]));
  // R8: misses drive a zero address
  a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> res_addr == '0);
  // R9: a hit is only ever flagged alongside a valid result
  a_r9_hit_in_valid: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_valid);
endmodule

// File: tb/fwh_remap_window_bench.sv
module fwh_remap_window_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_fw = 1'b0;
  logic [31:0] req_addr = '0;
  logic        res_valid;
  logic        res_hit;
  logic [31:0] res_addr;

  always #5 clk = ~clk;

  fwh_remap_window u_fwh_remap_window (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_fw(req_fw), .req_addr(req_addr), .res_valid(res_valid),
    .res_hit(res_hit), .res_addr(res_addr)
  );

  typedef struct {
    logic        hit;
    logic [31:0] addr;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;
  logic [31:0] sh_ctrl = '0, sh_base = '0, sh_mask = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [31:0] a, input logic fw,
                                 input string tag);
    exp_t e;
    logic [15:0] pg;
    logic en, match;
    pg    = a[31:16];
    en    = sh_ctrl[10] & sh_ctrl[8];
    match = ((pg ^ sh_base[15:0]) & ~sh_mask[15:0]) == 16'h0;
    e.hit = en & fw & match;
    e.addr = e.hit ? {(sh_base[31:16] & sh_mask[31:16]) | (pg & sh_mask[15:0]),
                      a[15:0]} : 32'h0;
    e.tag = tag;
    return e;
  endfunction

  // Monitor: compares each result against the oldest expected item
  always @(negedge clk) begin
    if (rst_n && !done && res_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected result", {31'h0, res_valid}, 32'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(res_hit == e.hit, {e.tag, " hit"}, {31'h0, res_hit}, {31'h0, e.hit});
        check(res_addr == e.addr, {e.tag, " addr"}, res_addr, e.addr);
      end
    end
  end

  task automatic send(input logic [31:0] a, input logic fw, input string tag);
    @(negedge clk);
    reg_wr = 1'b0; req_valid = 1'b1; req_fw = fw; req_addr = a;
    sb.push_back(model(a, fw, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    reg_wr = 1'b0; req_valid = 1'b0; req_fw = 1'b0;
  endtask

  task automatic shadow_wr(input logic [3:0] a, input logic [31:0] d);
    case (a)
      4'h0: sh_ctrl = d;
      4'h8: sh_base = d;
      4'hC: sh_mask = d;
      default: ;
    endcase
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b0; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    shadow_wr(a, d);
  endtask

  // R10: write and request in the same cycle; request uses old settings
  task automatic write_and_send(input logic [3:0] wa, input logic [31:0] d,
                                input logic [31:0] a, input string tag);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = wa; reg_wdata = d;
    req_valid = 1'b1; req_fw = 1'b1; req_addr = a;
    sb.push_back(model(a, 1'b1, tag));
    shadow_wr(wa, d);
  endtask

  task automatic reg_check(input logic [3:0] a, input logic [31:0] exp,
                           input string tag);
    @(negedge clk);
    reg_wr = 1'b0; req_valid = 1'b0; reg_addr = a;
    #1;
    check(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(res_valid == 1'b0 && res_hit == 1'b0 && res_addr == 32'h0,
          "R1 outputs after reset", res_addr, 32'h0);
    reg_check(4'h0, 32'h0, "R1 ctrl reset");
    reg_check(4'h8, 32'h0, "R1 base reset");
    reg_check(4'hC, 32'h0, "R1 mask reset");
    send(32'h0000_1234, 1'b1, "R1 disabled after reset");
    idle();
    // R2: register map and readback
    reg_write(4'h8, 32'h0E20_0FF0);
    reg_write(4'hC, 32'hFFF0_000F);
    reg_write(4'h4, 32'hDEAD_BEEF);
    reg_check(4'h8, 32'h0E20_0FF0, "R2 base readback");
    reg_check(4'hC, 32'hFFF0_000F, "R2 mask readback");
    reg_check(4'h4, 32'h0, "R2 unmapped reads zero");
    reg_check(4'h0, 32'h0, "R2 unmapped write ignored");
    // R3: single enable bits do not open the window
    reg_write(4'h0, 32'h0000_0400);
    send(32'h0FF3_1234, 1'b1, "R3 only bit10");
    reg_write(4'h0, 32'h0000_0100);
    send(32'h0FF3_1234, 1'b1, "R3 only bit8");
    reg_write(4'h0, 32'h0000_0500);
    reg_check(4'h0, 32'h0000_0500, "R2 ctrl readback");
    // R5/R6/R7: 1 MiB window hits
    send(32'h0FF3_1234, 1'b1, "R6 hit translate");
    send(32'h0FF0_0000, 1'b1, "R7 hit window start");
    send(32'h0FFF_FFFF, 1'b1, "R7 hit window end");
    // R4: non-firmware cycle
    send(32'h0FF3_1234, 1'b0, "R4 non-fw miss");
    // R5/R8: outside window
    send(32'h0FE3_1234, 1'b1, "R8 outside miss");
    send(32'h1FF3_0001, 1'b1, "R5 top bit mismatch");
    idle();
    // R10: base change in same cycle as request
    write_and_send(4'h8, 32'h3000_2000, 32'h0FF5_5555, "R10 old base used");
    send(32'h0FF5_5555, 1'b1, "R10 new base miss");
    send(32'h2005_5555, 1'b1, "R10 new base hit");
    idle();
    // R5/R6: irregular mask halves
    reg_write(4'hC, 32'hA5A5_0F0F);
    reg_write(4'h8, 32'h5A5A_C3C3);
    send(32'hC0C0_8888, 1'b1, "R5 irregular hit");
    send(32'hC3CF_0001, 1'b1, "R6 irregular keep");
    send(32'hD3C3_0001, 1'b1, "R5 irregular miss");
    // R5/R6: 64 KiB window, exact page match
    reg_write(4'hC, 32'hFFFF_0000);
    reg_write(4'h8, 32'h8765_4321);
    send(32'h4321_ABCD, 1'b1, "R6 64K hit");
    send(32'h4320_ABCD, 1'b1, "R5 64K neighbour miss");
    // Mixed pseudo-random traffic over a 16 MiB window
    reg_write(4'hC, 32'hFF00_00FF);
    reg_write(4'h8, 32'h1200_3400);
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr;
      if (lfsr[5]) a[31:16] = {8'h34, lfsr[23:16]};
      send(a, lfsr[9] | lfsr[3], "R6 mixed traffic");
      if (lfsr[12]) idle();
    end
    // R3: disabling closes the window again
    reg_write(4'h0, 32'h0000_0000);
    send(32'h3400_0000, 1'b1, "R3 disabled again");
    idle();
    idle();
    idle();
    check(sb.size() == 0, "R9 all results returned", sb.size(), 32'h0);
    finish_run();
  end
endmodule